// File: doc/BRIEF.md
# Wrapping Address Pointer Unit

This block keeps a small set of data-memory pointers for a signal-processing core. Each pointer has two companion registers. The first is a wrap register, which sets the size of a circular buffer the pointer moves around in. The second is an index register, which gives a stride. Each cycle the block can step one pointer up or down with wrap-around, or add its index to it. It can also move two pointers at once for paired loads. The current pointer values always appear on a flat combinational output, so the core can use them as addresses in the same cycle.

Wrap-around is found with bitwise tests, not with base and limit comparisons. Stepping down wraps when the pointer bits covered by the wrap register are all zero: those bits are then set. Stepping up uses a mask made from the wrap register by filling in every bit below its highest set bit. The step wraps when all masked pointer bits are ones, and the pointer is then XORed with the wrap value. A wrap value of all ones makes each pointer a plain up/down counter.

Software loads any register through a write port. Single-pointer updates come in as short 16-bit command words. A separate paired-update input steps a chosen pointer and the last pointer together.

Top module: `addr_wrap_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all pointers and index registers to 0 and sets all wrap registers to all ones.
- R2: When `wr_en` is high, `wr_data` is loaded at the rising edge into register `wr_sel` of the file chosen by `wr_file`: 0 pointer, 1 wrap, 2 index, 3 no register.
- R3: Stepping down: if (pointer AND wrap) is zero, the pointer becomes (pointer OR wrap); otherwise it becomes pointer minus one.
- R4: Stepping up: let the mask be the wrap value with every bit below its highest set bit also set. If (pointer AND mask) equals the mask, the pointer becomes (pointer XOR wrap); otherwise it becomes pointer plus one.
- R5: Index add sets the pointer to pointer plus index, modulo 2^16, with no wrap applied.
- R6: A command word with `cmd_valid` high acts only when bits 15:4 are zero. Bits 3:2 select the action: 01 step down, 10 step up, 11 index add, 00 none. Bits 1:0 select the pointer. Any other word leaves every pointer unchanged.
- R7: With `dual_en` high, pointer `dual_sel` steps up under R4. In the same cycle the last pointer (pointer 3) steps up when `dual_ix` is 0, or adds index 3 when `dual_ix` is 1. Any command word in that cycle is ignored.
- R8: If `dual_sel` is 3 during a paired update, pointer 3 takes only the action chosen by `dual_ix`, applied once.
- R9: A register-port write to a pointer wins over any update aimed at that pointer in the same cycle. An update in the same cycle as a write to its wrap or index register uses the old value.
- R10: With a wrap value of 0xFFFF, stepping up and down behave as plain 16-bit counters (0xFFFF+1 gives 0, 0-1 gives 0xFFFF).
- R11: `ptr_out[16n+15:16n]` always shows the registered value of pointer n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_file | input | 2 | Target file: 0 pointer, 1 wrap, 2 index |
| wr_sel | input | 2 | Register number within the file |
| wr_data | input | 16 | Write data |
| cmd_valid | input | 1 | Command word valid |
| cmd_word | input | 16 | Single-pointer command word |
| dual_en | input | 1 | Paired update strobe |
| dual_sel | input | 2 | First pointer of the paired update |
| dual_ix | input | 1 | Second pointer mode: 0 step up, 1 index add |
| ptr_out | output | 64 | All pointer values, pointer n at bits 16n+15:16n |

## Verification
The bench builds the block with its defaults: four pointers of 16 bits. This makes the command encoding exactly the 16-bit short form, and the last pointer is pointer 3. With 16-bit width the all-ones wrap value and the 0x0000/0xFFFF boundary crossings are reachable in one or two commands. Power-of-two buffer sizes (wrap 0x000F, 0x0007) and an uneven wrap value (0x000A) are all exercised, against a behavioural model that finds the mask by scanning for the top set bit.

// File: rtl/addr_wrap_pkg.sv
package addr_wrap_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_DOWN = 2'b01,
        STEP_UP   = 2'b10,
        STEP_ADD  = 2'b11
    } step_op_e;

    typedef enum logic [1:0] {
        FILE_PTR  = 2'd0,
        FILE_WRAP = 2'd1,
        FILE_IDX  = 2'd2,
        FILE_NONE = 2'd3
    } reg_file_e;
endpackage

// File: rtl/awu_smear.sv
module awu_smear #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] val,
    output logic [AW-1:0] mask
);
    localparam int STAGES = $clog2(AW);

    always_comb begin
        mask = val;
        for (int s = STAGES - 1; s >= 0; s--) begin
            mask = mask | (mask >> (1 << s));
        end
    end
endmodule

// File: rtl/awu_step.sv
module awu_step
    import addr_wrap_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] wrap,
    input  logic [AW-1:0] idx,
    input  step_op_e      op,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] up_mask;

    awu_smear #(.AW(AW)) u_smear (
        .val  (wrap),
        .mask (up_mask)
    );

    always_comb begin
        unique case (op)
            STEP_DOWN: nxt = ((cur & wrap) == '0) ? (cur | wrap) : (cur - 1'b1);
            STEP_UP:   nxt = ((cur & up_mask) == up_mask) ? (cur ^ wrap) : (cur + 1'b1);
            STEP_ADD:  nxt = cur + idx;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/awu_cmd_decode.sv
module awu_cmd_decode
    import addr_wrap_pkg::*;
#(
    parameter int CW   = 16,
    parameter int SELW = 2
) (
    input  logic            valid,
    input  logic [CW-1:0]   word,
    output logic            hit,
    output step_op_e        op,
    output logic [SELW-1:0] sel
);
    localparam int OP_LO = SELW;
    localparam int HI_LO = SELW + 2;

    always_comb begin
        sel = word[SELW-1:0];
        op  = step_op_e'(word[OP_LO+1:OP_LO]);
        hit = valid && (word[CW-1:HI_LO] == '0) && (op != STEP_NONE);
    end
endmodule

// File: rtl/addr_wrap_unit.sv
module addr_wrap_unit
    import addr_wrap_pkg::*;
#(
    parameter int NUM_PTR = 4,
    parameter int AW      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_file,
    input  logic [1:0]              wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    cmd_valid,
    input  logic [AW-1:0]           cmd_word,
    input  logic                    dual_en,
    input  logic [1:0]              dual_sel,
    input  logic                    dual_ix,
    output logic [NUM_PTR*AW-1:0]   ptr_out
);
    localparam int SELW = $clog2(NUM_PTR);
    localparam int LAST = NUM_PTR - 1;

    typedef struct packed {
        logic [NUM_PTR-1:0][AW-1:0] ptr;
        logic [NUM_PTR-1:0][AW-1:0] wrap;
        logic [NUM_PTR-1:0][AW-1:0] idx;
    } state_t;

    state_t st_d, st_q;

    logic            cmd_hit;
    step_op_e        cmd_op;
    logic [SELW-1:0] cmd_sel;
    step_op_e        op_q [NUM_PTR];
    logic [AW-1:0]   step_nxt [NUM_PTR];

    awu_cmd_decode #(.CW(AW), .SELW(SELW)) u_dec (
        .valid (cmd_valid),
        .word  (cmd_word),
        .hit   (cmd_hit),
        .op    (cmd_op),
        .sel   (cmd_sel)
    );

    // per-pointer action selection
    always_comb begin
        for (int n = 0; n < NUM_PTR; n++) begin
            op_q[n] = STEP_NONE;
            if (dual_en) begin
                if (n == LAST)
                    op_q[n] = dual_ix ? STEP_ADD : STEP_UP;
                else if (dual_sel == SELW'(n))
                    op_q[n] = STEP_UP;
            end else if (cmd_hit && cmd_sel == SELW'(n)) begin
                op_q[n] = cmd_op;
            end
        end
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_step
        awu_step #(.AW(AW)) u_step (
            .cur  (st_q.ptr[g]),
            .wrap (st_q.wrap[g]),
            .idx  (st_q.idx[g]),
            .op   (op_q[g]),
            .nxt  (step_nxt[g])
        );
        assign ptr_out[g*AW +: AW] = st_q.ptr[g];
    end

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NUM_PTR; n++) begin
            st_d.ptr[n] = step_nxt[n];
            if (wr_en && wr_sel == SELW'(n)) begin
                unique case (reg_file_e'(wr_file))
                    FILE_PTR:  st_d.ptr[n]  = wr_data;
                    FILE_WRAP: st_d.wrap[n] = wr_data;
                    FILE_IDX:  st_d.idx[n]  = wr_data;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ptr  <= '0;
            st_q.wrap <= '1;
            st_q.idx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/addr_wrap_unit_chk.sv
module addr_wrap_unit_chk #(
    parameter int NUM_PTR = 4,
    parameter int AW      = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [1:0]            wr_file,
    input logic [1:0]            wr_sel,
    input logic [AW-1:0]         wr_data,
    input logic                  cmd_valid,
    input logic [AW-1:0]         cmd_word,
    input logic                  dual_en,
    input logic [1:0]            dual_sel,
    input logic [NUM_PTR*AW-1:0] ptr_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> ptr_out == '0);

    // R9
    ptr_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_file == 2'd0) |=> ptr_out[$past(wr_sel)*AW +: AW] == $past(wr_data));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !dual_en && !cmd_valid) |=> $stable(ptr_out));

    // R6
    bad_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !dual_en && cmd_valid && cmd_word[AW-1:4] != '0) |=> $stable(ptr_out));

    // R7
    dual_others_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && dual_en && dual_sel == 2'd0) |=> $stable(ptr_out[AW +: 2*AW]));
endmodule

bind addr_wrap_unit addr_wrap_unit_chk #(.NUM_PTR(NUM_PTR), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_file   (wr_file),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .dual_en   (dual_en),
    .dual_sel  (dual_sel),
    .ptr_out   (ptr_out)
);

// File: tb/addr_wrap_unit_bench.sv
module addr_wrap_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_file;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        dual_en;
    logic [1:0]  dual_sel;
    logic        dual_ix;
    logic [63:0] ptr_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_ptr [4];
    logic [15:0] m_wrap [4];
    logic [15:0] m_idx [4];

    always #2 clk = ~clk;

    addr_wrap_unit u_addr_wrap_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_file(wr_file), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dual_en(dual_en), .dual_sel(dual_sel), .dual_ix(dual_ix), .ptr_out(ptr_out)
    );

    function automatic logic [15:0] fill_mask(logic [15:0] w);
        logic [15:0] m = 16'h0;
        bit seen = 0;
        for (int b = 15; b >= 0; b--) begin
            if (w[b]) seen = 1;
            if (seen) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [15:0] go_up(logic [15:0] p, logic [15:0] w);
        logic [15:0] m = fill_mask(w);
        if ((p & m) == m) return p ^ w;
        return p + 16'd1;
    endfunction

    function automatic logic [15:0] go_down(logic [15:0] p, logic [15:0] w);
        if ((p & w) == 16'h0) return p | w;
        return p - 16'd1;
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_file = 0; wr_sel = 0; wr_data = 0;
        cmd_valid = 0; cmd_word = 0; dual_en = 0; dual_sel = 0; dual_ix = 0;
    endtask

    // advance one clock; model computed from the inputs held across the edge
    task automatic tick();
        logic [15:0] np [4];
        logic [15:0] nw [4];
        logic [15:0] ni [4];
        for (int n = 0; n < 4; n++) begin
            np[n] = m_ptr[n]; nw[n] = m_wrap[n]; ni[n] = m_idx[n];
        end
        if (rst) begin
            for (int n = 0; n < 4; n++) begin
                np[n] = 0; nw[n] = 16'hFFFF; ni[n] = 0;
            end
        end else begin
            if (dual_en) begin
                if (dual_sel != 2'd3) np[dual_sel] = go_up(m_ptr[dual_sel], m_wrap[dual_sel]);
                np[3] = dual_ix ? m_ptr[3] + m_idx[3] : go_up(m_ptr[3], m_wrap[3]);
            end else if (cmd_valid && cmd_word[15:4] == 0) begin
                case (cmd_word[3:2])
                    2'b01: np[cmd_word[1:0]] = go_down(m_ptr[cmd_word[1:0]], m_wrap[cmd_word[1:0]]);
                    2'b10: np[cmd_word[1:0]] = go_up(m_ptr[cmd_word[1:0]], m_wrap[cmd_word[1:0]]);
                    2'b11: np[cmd_word[1:0]] = m_ptr[cmd_word[1:0]] + m_idx[cmd_word[1:0]];
                    default: ;
                endcase
            end
            if (wr_en) begin
                case (wr_file)
                    2'd0: np[wr_sel] = wr_data;
                    2'd1: nw[wr_sel] = wr_data;
                    2'd2: ni[wr_sel] = wr_data;
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < 4; n++) begin
            m_ptr[n] = np[n]; m_wrap[n] = nw[n]; m_idx[n] = ni[n];
            chk("R11 model", ptr_out[n*16 +: 16], m_ptr[n]);
        end
        idle();
    endtask

    task automatic wreg(logic [1:0] f, logic [1:0] s, logic [15:0] d);
        wr_en = 1; wr_file = f; wr_sel = s; wr_data = d;
        tick();
    endtask

    task automatic cmd(logic [15:0] w);
        cmd_valid = 1; cmd_word = w;
        tick();
    endtask

    function automatic logic [15:0] p(int n);
        return ptr_out[n*16 +: 16];
    endfunction

    initial begin
        for (int n = 0; n < 4; n++) begin
            m_ptr[n] = 16'hDEAD; m_wrap[n] = 0; m_idx[n] = 0;
        end
        idle();
        rst = 1;
        tick();
        tick();
        rst = 0;
        chk("R1 reset ptr0", p(0), 16'h0000);
        chk("R1 reset ptr3", p(3), 16'h0000);

        wreg(2'd0, 2'd0, 16'h0130);
        wreg(2'd1, 2'd0, 16'h000F);
        chk("R2 write ptr0", p(0), 16'h0130);
        wreg(2'd3, 2'd0, 16'h7777);
        chk("R2 file 3 no effect", p(0), 16'h0130);

        cmd(16'h0004);
        chk("R3 down wraps", p(0), 16'h013F);
        cmd(16'h0004);
        chk("R3 down plain", p(0), 16'h013E);

        wreg(2'd0, 2'd0, 16'h013F);
        cmd(16'h0008);
        chk("R4 up wraps", p(0), 16'h0130);
        cmd(16'h0008);
        chk("R4 up plain", p(0), 16'h0131);

        wreg(2'd1, 2'd1, 16'h000A);
        wreg(2'd0, 2'd1, 16'h0045);
        cmd(16'h0009);
        chk("R4 uneven wrap", p(1), 16'h0046);
        wreg(2'd0, 2'd1, 16'h004F);
        cmd(16'h0009);
        chk("R4 uneven wrap edge", p(1), 16'h0045);

        cmd(16'h0006);
        chk("R10 down from 0", p(2), 16'hFFFF);
        cmd(16'h000A);
        chk("R10 up from FFFF", p(2), 16'h0000);
        cmd(16'h000A);
        chk("R10 up plain", p(2), 16'h0001);

        wreg(2'd1, 2'd1, 16'h000F);
        wreg(2'd2, 2'd1, 16'hFFF0);
        wreg(2'd0, 2'd1, 16'h0020);
        cmd(16'h000D);
        chk("R5 add index modular", p(1), 16'h0010);

        cmd(16'h0014);
        chk("R6 upper bits ignored", p(0), 16'h0131);
        cmd(16'h0000);
        chk("R6 op 00 ignored", p(0), 16'h0131);

        wreg(2'd0, 2'd0, 16'h0130);
        wreg(2'd1, 2'd3, 16'h0007);
        wreg(2'd0, 2'd3, 16'h0017);
        wreg(2'd2, 2'd3, 16'h0100);
        dual_en = 1; dual_sel = 0; dual_ix = 0; cmd_valid = 1; cmd_word = 16'h0005;
        tick();
        chk("R7 first ptr up", p(0), 16'h0131);
        chk("R7 last ptr up wraps", p(3), 16'h0010);
        chk("R7 command ignored", p(1), 16'h0010);
        dual_en = 1; dual_sel = 1; dual_ix = 1;
        tick();
        chk("R7 last ptr add index", p(3), 16'h0110);
        chk("R7 ptr1 up", p(1), 16'h0011);

        dual_en = 1; dual_sel = 3; dual_ix = 1;
        tick();
        chk("R8 single add", p(3), 16'h0210);

        wr_en = 1; wr_file = 0; wr_sel = 0; wr_data = 16'h5555;
        cmd_valid = 1; cmd_word = 16'h0008;
        tick();
        chk("R9 write wins", p(0), 16'h5555);
        wr_en = 1; wr_file = 1; wr_sel = 0; wr_data = 16'h0003;
        cmd_valid = 1; cmd_word = 16'h0008;
        tick();
        chk("R9 old wrap used", p(0), 16'h5556);

        for (int i = 0; i < 300; i++) begin
            wr_en     = ($urandom_range(0, 3) == 0);
            wr_file   = 2'($urandom_range(0, 3));
            wr_sel    = 2'($urandom_range(0, 3));
            wr_data   = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 65535))
                                                    : 16'((1 << $urandom_range(0, 5)) - 1);
            cmd_valid = ($urandom_range(0, 1) == 1);
            cmd_word  = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(0, 65535))
                                                    : 16'($urandom_range(0, 15));
            dual_en   = ($urandom_range(0, 4) == 0);
            dual_sel  = 2'($urandom_range(0, 3));
            dual_ix   = 1'($urandom_range(0, 1));
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule